// File: doc/BRIEF.md
# Indexed Address Generation Sequencer

This block forms the effective address of an indexed memory operand on a processor bus that has 8-bit data and 16-bit addresses. The only arithmetic it uses is a single 8-bit adder, applied once to add the index to the low base byte and once more to carry into the high byte. Two addressing modes are supported. Absolute-indexed takes a two-byte base from the instruction stream. Zero-page-indexed takes a one-byte base and stays inside page zero.

A start pulse is sampled at the end of the opcode fetch cycle, which counts as cycle 1. From then on the block owns the bus. It reads the operand byte or bytes, then performs the data access and signals completion with a one-cycle done pulse. A load first reads from the address whose high byte has not yet been corrected. That read is repeated at the corrected address only when the low-byte add carried. A store never writes to the uncorrected address. In absolute-indexed mode a store always spends the extra correction cycle, so its timing is fixed.

Top module: `idx_addr_seq`

## Requirements
- R1: After reset, bus_act, bus_we and done are 0, bus_addr and bus_wdata are 0, and load_data is 0.
- R2: The cycle after start is accepted is cycle 2. It reads from operand_addr. In absolute-indexed mode (abs_mode=1), cycle 3 reads the high base byte from operand_addr+1, using a full 16-bit increment.
- R3: In zero-page-indexed mode (abs_mode=0), cycle 3 is a dummy read at {8'h00, base}. Cycle 4 accesses {8'h00, (base+index) mod 256}. Any carry is dropped, and both loads and stores end in cycle 4.
- R4: An absolute-indexed load whose low-byte add does not carry reads {high, low+index} in cycle 4 and ends there. load_data is the byte read in that cycle.
- R5: An absolute-indexed load whose low-byte add carries reads {high, low+index} in cycle 4 and discards the result. It then reads {high+1 mod 256, low+index} in cycle 5 and returns that byte.
- R6: An absolute-indexed store reads, with bus_we=0, at {high, low+index} in cycle 4. It writes in cycle 5 at {high+carry, low+index}, whether or not a carry occurred.
- R7: bus_we is 1 only in the final cycle of a store. bus_wdata equals the latched store data while bus_we is 1 and is 0 otherwise.
- R8: done is 1 for exactly one cycle, the last bus cycle of an access. load_data keeps the last loaded byte until the next load completes, and a store leaves it unchanged.
- R9: A start pulse that arrives while an access is in progress is ignored. The access in progress keeps its sequence.
- R10: bus_act is 1 from cycle 2 through the last bus cycle, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an access. Sampled at the end of the opcode fetch cycle |
| abs_mode | input | 1 | 1 = absolute-indexed, 0 = zero-page-indexed |
| is_store | input | 1 | 1 = store, 0 = load |
| index | input | 8 | Index register value |
| store_data | input | 8 | Byte to write for a store |
| operand_addr | input | 16 | Address of the first operand byte after the opcode |
| bus_rdata | input | 8 | Read-data bus, sampled every active cycle |
| bus_act | output | 1 | The sequencer owns the bus this cycle |
| bus_addr | output | 16 | Address bus |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata | output | 8 | Write-data bus |
| done | output | 1 | Last bus cycle of the access |
| load_data | output | 8 | Loaded byte, valid from done until the next load completes |

## Verification
The hardest case to reach from the ports is a carry into a high base byte of 0xFF. In that case the correction must wrap to page zero, in cycle 5 only, after a discarded speculative read. The bench reaches it with a memory model in which the operand bytes are set per scenario. This places 0xFF at operand_addr+1 and chooses a low byte and index whose sum overflows. The bench checks every bus cycle of every access against addresses it computes itself. This also covers a store whose add does not carry but which must still spend cycle 5.

// File: rtl/idx_addr_seq.sv
module idx_addr_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abs_mode,
  input  logic        is_store,
  input  logic [7:0]  index,
  input  logic [7:0]  store_data,
  input  logic [15:0] operand_addr,
  input  logic [7:0]  bus_rdata,
  output logic        bus_act,
  output logic [15:0] bus_addr,
  output logic        bus_we,
  output logic [7:0]  bus_wdata,
  output logic        done,
  output logic [7:0]  load_data
);
  typedef enum logic [2:0] {S_IDLE, S_OPND, S_HIGH, S_DUMMY, S_SPEC, S_FIX} st_t;

  st_t         st;
  logic        abs_q, str_q, cy_q;
  logic [7:0]  idx_q, wd_q, lo_q, hi_q, ld_q;
  logic [15:0] opa_q;

  logic [7:0] add_a, add_b, add_s;
  logic       add_c, last;

  // single 8-bit adder: index add in cycle 3, high-byte increment in cycle 4
  assign add_a = (st == S_SPEC) ? hi_q  : lo_q;
  assign add_b = (st == S_SPEC) ? 8'h01 : idx_q;
  assign {add_c, add_s} = {1'b0, add_a} + {1'b0, add_b};

  assign last = (st == S_FIX) ||
                (st == S_SPEC && (!abs_q || (!str_q && !cy_q)));

  assign bus_act   = (st != S_IDLE);
  assign bus_we    = str_q && ((st == S_FIX) || (st == S_SPEC && !abs_q));
  assign bus_wdata = bus_we ? wd_q : 8'h00;
  assign done      = last;
  assign load_data = (last && !str_q) ? bus_rdata : ld_q;

  always_comb begin
    case (st)
      S_OPND:  bus_addr = opa_q;
      S_HIGH:  bus_addr = opa_q + 16'd1;
      S_DUMMY: bus_addr = {8'h00, lo_q};
      S_SPEC:  bus_addr = {hi_q, lo_q};
      S_FIX:   bus_addr = {hi_q, lo_q};
      default: bus_addr = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      abs_q <= 1'b0; str_q <= 1'b0; cy_q <= 1'b0;
      idx_q <= 8'h00; wd_q <= 8'h00; lo_q <= 8'h00; hi_q <= 8'h00;
      ld_q <= 8'h00; opa_q <= 16'h0000;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          abs_q <= abs_mode; str_q <= is_store; idx_q <= index;
          wd_q <= store_data; opa_q <= operand_addr;
          st <= S_OPND;
        end
        S_OPND: begin
          lo_q <= bus_rdata;
          st   <= abs_q ? S_HIGH : S_DUMMY;
        end
        S_HIGH: begin
          hi_q <= bus_rdata; lo_q <= add_s; cy_q <= add_c;
          st   <= S_SPEC;
        end
        S_DUMMY: begin
          hi_q <= 8'h00; lo_q <= add_s; cy_q <= 1'b0;
          st   <= S_SPEC;
        end
        S_SPEC: if (last) begin
          if (!str_q) ld_q <= bus_rdata;
          st <= S_IDLE;
        end else begin
          if (cy_q) hi_q <= add_s;
          st <= S_FIX;
        end
        S_FIX: begin
          if (!str_q) ld_q <= bus_rdata;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_we_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_act && done));
  a_r7_wdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |-> (bus_wdata == 8'h00));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> $stable(ld_q));
  a_r6_spec_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SPEC && abs_q) |-> !bus_we);
  a_r5_fix_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX) |-> (bus_addr[15:8] == ($past(bus_addr[15:8]) + {7'd0, cy_q})));
  a_r5_fix_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX) |-> $stable(bus_addr[7:0]));
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && start) |=> (st != S_OPND));
endmodule

// File: tb/tb_idx_addr_seq.sv
module tb_idx_addr_seq;
  logic clk = 0, rst_n = 0, start = 0, abs_mode = 0, is_store = 0;
  logic [7:0] index = 0, store_data = 0;
  logic [15:0] operand_addr = 0;
  logic [7:0] bus_rdata;
  logic bus_act, bus_we, done;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, load_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] op_at = 16'h0000;
  logic [7:0]  op_lo = 0, op_hi = 0, exp_ld = 0;

  always #10 clk = ~clk;

  idx_addr_seq dut (.*);

  function automatic logic [7:0] mem(input logic [15:0] a);
    if (a == op_at) return op_lo;
    if (a == op_at + 16'd1) return op_hi;
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign bus_rdata = mem(bus_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic am, input logic st,
                        input logic [15:0] pa, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] ix, input logic [7:0] wd, input logic poke);
    logic [15:0] ea [4];
    logic        ew [4];
    logic [8:0]  s;
    int n;
    op_at = pa; op_lo = lo; op_hi = am ? hi : 8'h00;
    s = {1'b0, lo} + {1'b0, ix};
    ea[0] = pa; ew[0] = 0;
    ea[1] = am ? pa + 16'd1 : {8'h00, lo}; ew[1] = 0;
    ea[2] = am ? {hi, s[7:0]} : {8'h00, s[7:0]}; ew[2] = !am && st;
    ea[3] = {hi + {7'd0, s[8]}, s[7:0]}; ew[3] = st;
    n = (!am || (!st && !s[8])) ? 3 : 4;
    @(negedge clk);
    abs_mode = am; is_store = st; operand_addr = pa; index = ix; store_data = wd; start = 1;
    @(negedge clk);
    start = 0; abs_mode = !am; is_store = !st; operand_addr = 16'hBEEF; index = 8'h77; store_data = 8'h99;
    for (int i = 0; i < n; i++) begin
      chk({tag, " R10 act"}, bus_act, 1);
      chk({tag, " addr"}, bus_addr, ea[i]);
      chk({tag, " R7 we"}, bus_we, ew[i]);
      chk({tag, " R7 wdata"}, bus_wdata, ew[i] ? wd : 8'h00);
      chk({tag, " R8 done"}, done, i == n - 1);
      if (i == n - 1 && !st) begin
        exp_ld = mem(ea[i]);
        chk({tag, " load_data"}, load_data, exp_ld);
      end
      if (poke && i == 1) start = 1; else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk({tag, " R10 idle"}, bus_act, 0);
    chk({tag, " R8 done low"}, done, 0);
    chk({tag, " R8 hold"}, load_data, exp_ld);
    @(negedge clk);
    chk({tag, " R8 hold2"}, load_data, exp_ld);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 act", bus_act, 0);
    chk("R1 we", bus_we, 0);
    chk("R1 done", done, 0);
    chk("R1 addr", bus_addr, 0);
    chk("R1 wdata", bus_wdata, 0);
    chk("R1 load_data", load_data, 0);
    rst_n = 1;
    run_op("R2 R4 abs load no carry", 1, 0, 16'h0400, 8'h80, 8'h03, 8'h10, 8'h00, 0);
    run_op("R5 abs load carry", 1, 0, 16'h0400, 8'hF0, 8'h03, 8'h20, 8'h00, 0);
    run_op("R5 abs load carry high FF", 1, 0, 16'h21FF, 8'hC0, 8'hFF, 8'h41, 8'h00, 0);
    run_op("R6 abs store no carry", 1, 1, 16'h0600, 8'h12, 8'h34, 8'h05, 8'h5C, 0);
    run_op("R6 R8 abs store carry", 1, 1, 16'h0700, 8'hFF, 8'h80, 8'h01, 8'hC3, 0);
    run_op("R3 zp load wrap", 0, 0, 16'h0300, 8'hF0, 8'h00, 8'h20, 8'h00, 0);
    run_op("R3 zp store", 0, 1, 16'h0310, 8'h40, 8'h00, 8'h02, 8'h3E, 0);
    run_op("R9 busy start abs", 1, 0, 16'h0800, 8'hE0, 8'h11, 8'h30, 8'h00, 1);
    run_op("R9 busy start zp", 0, 0, 16'h0900, 8'h10, 8'h00, 8'h01, 8'h00, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule